// File: doc/BRIEF.md
# Segmented Kernel Address Translator

This block is the entry stage of an address translation unit. For each access it makes one of three routing decisions. The access can bypass translation. It can be mapped straight through a per-segment base nibble. Or it can be handed on to a paged lookup that lives outside this block. The 32-bit address space is split into sixteen 256 MB segments, numbered by the top four address bits.

Software can place any segment in direct-mapped mode by setting that segment's bit in a segment map. The mode applies to kernel-mode accesses only. A direct-mapped address keeps its low 28 bits. Its top nibble is taken from one of two packed kernel-base registers: the low register serves segments 0 to 7 and the high register serves segments 8 to 15. Direct-mapped and bypassed accesses never fault and are granted full permission. All other accesses raise a request for the paged lookup.

The decision is combinational and has three named routes: ROUTE_BYPASS, ROUTE_DIRECT and ROUTE_PAGED. The route is recomputed from the inputs on every cycle, so no state carries over from one access to the next. A parameter adds one output register stage; the default has this stage fitted.

Top module: `xlt_front`

## Requirements
- R1: When both bits of `xlat_mode` are 0, translation is off. `paddr` equals `vaddr`, `full_perm` is 1 and `page_req` is 0, whatever the other inputs are.
- R2: The segment number is `vaddr[31:28]`. With translation on, the route is direct only when `seg_map[segment]` is 1 and `user_mode` is 0.
- R3: On a direct route, segments 0 to 7 take their base nibble from `kbase_lo` and segments 8 to 15 take it from `kbase_hi`. The nibble sits at bits `[(segment mod 8)*4 +: 4]` of the selected register.
- R4: On a direct route, `paddr[31:28]` is the base nibble and `paddr[27:0]` equals `vaddr[27:0]`.
- R5: On a direct route, `full_perm` is 1 and `page_req` is 0.
- R6: With translation on, a user-mode access always gives `page_req` 1 and `full_perm` 0, even when its segment bit is set.
- R7: With translation on, a kernel access to a segment whose map bit is 0 gives `page_req` 1 and `full_perm` 0.
- R8: Whenever `page_req` is 1, `paddr` carries `vaddr` unchanged.
- R9: With OUT_REG=1 (the default), the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R10: Outside reset, exactly one of `full_perm` and `page_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| vaddr | input | 32 | Virtual address of the access |
| user_mode | input | 1 | 1 for a user-mode access |
| xlat_mode | input | 2 | Translation enable field; nonzero turns translation on |
| seg_map | input | 16 | One direct-map enable bit per segment, indexed by segment number |
| kbase_lo | input | 32 | Packed base nibbles for segments 0 to 7 |
| kbase_hi | input | 32 | Packed base nibbles for segments 8 to 15 |
| paddr | output | 32 | Physical address, or the forwarded virtual address on a paged route |
| full_perm | output | 1 | Read, write and execute granted with no fault |
| page_req | output | 1 | Access must go to the paged lookup |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that the inputs the checker captures at an edge are the same ones the output stage captures there. In other words, inputs change only between clock edges. The stimulus respects this by driving every input on the falling edge from fully defined values. It sweeps all sixteen segments in both privilege modes, first with every map bit set and then with every map bit clear, using fresh random base registers and offsets for each access. It also covers each single enable bit alone, a random map, and the case where translation is off.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    typedef enum logic [1:0] {
        ROUTE_BYPASS = 2'd0,
        ROUTE_DIRECT = 2'd1,
        ROUTE_PAGED  = 2'd2
    } route_e;
endpackage

// File: rtl/xlt_route_sel.sv
module xlt_route_sel
    import xlt_pkg::*;
#(
    parameter int SEG_BITS = 4,
    localparam int NUM_SEG = 2 ** SEG_BITS
) (
    input  logic [1:0]          xlat_mode,
    input  logic [NUM_SEG-1:0]  seg_map,
    input  logic [SEG_BITS-1:0] seg,
    input  logic                user_mode,
    output route_e              route
);
    logic xlat_on;
    logic direct_ok;

    assign xlat_on   = |xlat_mode;
    assign direct_ok = seg_map[seg] & ~user_mode;

    always_comb begin
        unique case ({xlat_on, direct_ok})
            2'b00, 2'b01: route = ROUTE_BYPASS;
            2'b11:        route = ROUTE_DIRECT;
            default:      route = ROUTE_PAGED;
        endcase
    end
endmodule

// File: rtl/xlt_base_pick.sv
module xlt_base_pick #(
    parameter int SEG_BITS = 4,
    localparam int NUM_SEG = 2 ** SEG_BITS,
    localparam int HALF    = NUM_SEG / 2,
    localparam int KB_W    = HALF * SEG_BITS
) (
    input  logic [KB_W-1:0]     kbase_lo,
    input  logic [KB_W-1:0]     kbase_hi,
    input  logic [SEG_BITS-1:0] seg,
    output logic [SEG_BITS-1:0] nibble
);
    logic [SEG_BITS-1:0] nib_arr [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        if (g < HALF) begin : g_lo
            assign nib_arr[g] = kbase_lo[g*SEG_BITS +: SEG_BITS];
        end else begin : g_hi
            assign nib_arr[g] = kbase_hi[(g-HALF)*SEG_BITS +: SEG_BITS];
        end
    end

    assign nibble = nib_arr[seg];
endmodule

// File: rtl/xlt_out_stage.sv
module xlt_out_stage #(
    parameter int W       = 34,
    parameter int OUT_REG = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (OUT_REG != 0) begin : g_reg
        logic [W-1:0] q_r;
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d;
        end
        assign q = q_r;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign q = d;
    end
endmodule

// File: rtl/xlt_front.sv
module xlt_front
    import xlt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEG_BITS = 4,
    parameter int OUT_REG  = 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    vaddr,
    input  logic                                 user_mode,
    input  logic [1:0]                           xlat_mode,
    input  logic [(2**SEG_BITS)-1:0]             seg_map,
    input  logic [(2**SEG_BITS)/2*SEG_BITS-1:0]  kbase_lo,
    input  logic [(2**SEG_BITS)/2*SEG_BITS-1:0]  kbase_hi,
    output logic [ADDR_W-1:0]                    paddr,
    output logic                                 full_perm,
    output logic                                 page_req
);
    localparam int OFF_W = ADDR_W - SEG_BITS;
    localparam int OUT_W = ADDR_W + 2;

    logic [SEG_BITS-1:0] seg;
    logic [SEG_BITS-1:0] nibble;
    route_e              route;
    logic [ADDR_W-1:0]   paddr_c;
    logic                perm_c;
    logic                req_c;

    assign seg = vaddr[ADDR_W-1 -: SEG_BITS];

    xlt_route_sel #(.SEG_BITS(SEG_BITS)) u_route (
        .xlat_mode (xlat_mode),
        .seg_map   (seg_map),
        .seg       (seg),
        .user_mode (user_mode),
        .route     (route)
    );

    xlt_base_pick #(.SEG_BITS(SEG_BITS)) u_base (
        .kbase_lo (kbase_lo),
        .kbase_hi (kbase_hi),
        .seg      (seg),
        .nibble   (nibble)
    );

    always_comb begin
        paddr_c = vaddr;
        perm_c  = 1'b0;
        req_c   = 1'b0;
        unique case (route)
            ROUTE_BYPASS: perm_c = 1'b1;
            ROUTE_DIRECT: begin
                paddr_c = {nibble, vaddr[OFF_W-1:0]};
                perm_c  = 1'b1;
            end
            default:      req_c = 1'b1;
        endcase
    end

    xlt_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({paddr_c, perm_c, req_c}),
        .q     ({paddr, full_perm, page_req})
    );
endmodule

// File: rtl/xlt_front_chk.sv
module xlt_front_chk #(
    parameter int ADDR_W   = 32,
    parameter int SEG_BITS = 4,
    parameter int OUT_REG  = 1,
    localparam int NUM_SEG = 2 ** SEG_BITS,
    localparam int KB_W    = NUM_SEG / 2 * SEG_BITS,
    localparam int OFF_W   = ADDR_W - SEG_BITS
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   vaddr,
    input logic                user_mode,
    input logic [1:0]          xlat_mode,
    input logic [NUM_SEG-1:0]  seg_map,
    input logic [KB_W-1:0]     kbase_lo,
    input logic [KB_W-1:0]     kbase_hi,
    input logic [ADDR_W-1:0]   paddr,
    input logic                full_perm,
    input logic                page_req
);
    logic [ADDR_W-1:0]  va_d;
    logic               um_d;
    logic [1:0]         xm_d;
    logic [NUM_SEG-1:0] sm_d;
    logic [KB_W-1:0]    lo_d, hi_d;
    logic               seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            va_d <= '0; um_d <= 1'b0; xm_d <= '0;
            sm_d <= '0; lo_d <= '0;   hi_d <= '0;
        end else begin
            seen <= 1'b1;
            va_d <= vaddr; um_d <= user_mode; xm_d <= xlat_mode;
            sm_d <= seg_map; lo_d <= kbase_lo; hi_d <= kbase_hi;
        end
    end

    logic [ADDR_W-1:0]   va;
    logic                um;
    logic [1:0]          xm;
    logic [NUM_SEG-1:0]  sm;
    logic [KB_W-1:0]     bank;
    logic [SEG_BITS-1:0] sg;
    logic [SEG_BITS-1:0] want_nib;
    logic                live;

    assign va   = (OUT_REG != 0) ? va_d : vaddr;
    assign um   = (OUT_REG != 0) ? um_d : user_mode;
    assign xm   = (OUT_REG != 0) ? xm_d : xlat_mode;
    assign sm   = (OUT_REG != 0) ? sm_d : seg_map;
    assign sg   = va[ADDR_W-1 -: SEG_BITS];
    assign bank = sg[SEG_BITS-1] ? ((OUT_REG != 0) ? hi_d : kbase_hi)
                                 : ((OUT_REG != 0) ? lo_d : kbase_lo);
    assign want_nib = bank[sg[SEG_BITS-2:0]*SEG_BITS +: SEG_BITS];
    assign live = (OUT_REG != 0) ? seen : 1'b1;

    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xm == 2'b00) |-> (paddr == va && full_perm && !page_req));

    assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xm != 2'b00 && !um && sm[sg])
            |-> (paddr[OFF_W-1:0] == va[OFF_W-1:0] && paddr[ADDR_W-1 -: SEG_BITS] == want_nib));

    assert_direct_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xm != 2'b00 && !um && sm[sg]) |-> (full_perm && !page_req));

    assert_user_paged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xm != 2'b00 && um) |-> (page_req && !full_perm));

    assert_clear_paged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && xm != 2'b00 && !sm[sg]) |-> (page_req && !full_perm));

    assert_paged_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && page_req) |-> (paddr == va));

    assert_one_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ($countones({full_perm, page_req}) == 1));
endmodule

bind xlt_front xlt_front_chk #(
    .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/xlt_front_test.sv
module xlt_front_test;
    typedef struct {
        logic [31:0] paddr;
        logic        perm;
        logic        req;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] vaddr = '0;
    logic        user_mode = 1'b0;
    logic [1:0]  xlat_mode = '0;
    logic [15:0] seg_map = '0;
    logic [31:0] kbase_lo = '0;
    logic [31:0] kbase_hi = '0;
    logic [31:0] paddr;
    logic        full_perm;
    logic        page_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    xlt_front uut (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .user_mode(user_mode),
        .xlat_mode(xlat_mode), .seg_map(seg_map), .kbase_lo(kbase_lo),
        .kbase_hi(kbase_hi), .paddr(paddr), .full_perm(full_perm),
        .page_req(page_req)
    );

    function automatic exp_t model(logic [31:0] va, logic um, logic [1:0] xm,
                                   logic [15:0] sm, logic [31:0] lo, logic [31:0] hi);
        exp_t e;
        int s;
        logic [31:0] src;
        s = int'(va[31:28]);
        e.paddr = va; e.perm = 1'b0; e.req = 1'b0;
        if (xm == 2'b00) begin
            e.perm = 1'b1; e.tag = "R1";
        end else if (um) begin
            e.req = 1'b1; e.tag = "R6/R8";
        end else if (!sm[s]) begin
            e.req = 1'b1; e.tag = "R2/R7/R8";
        end else begin
            src = (s >= 8) ? hi : lo;
            e.paddr = {src[(s % 8) * 4 +: 4], va[27:0]};
            e.perm = 1'b1; e.tag = "R2/R3/R4/R5";
        end
        return e;
    endfunction

    task automatic drive(logic [31:0] va, logic um, logic [1:0] xm,
                         logic [15:0] sm, logic [31:0] lo, logic [31:0] hi);
        @(negedge clk);
        vaddr = va; user_mode = um; xlat_mode = xm;
        seg_map = sm; kbase_lo = lo; kbase_hi = hi;
        @(posedge clk);
        sb.push_back(model(va, um, xm, sm, lo, hi));
    endtask

    // Monitor: one result per cycle, one cycle after capture (R9)
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (paddr !== e.paddr || full_perm !== e.perm || page_req !== e.req) begin
                errors++;
                $display("FAIL %s (R9 timing): got paddr=%h perm=%b req=%b, expected paddr=%h perm=%b req=%b",
                         e.tag, paddr, full_perm, page_req, e.paddr, e.perm, e.req);
            end
            checks++;
            if ((full_perm ^ page_req) !== 1'b1) begin
                errors++;
                $display("FAIL R10: got perm=%b req=%b, expected exactly one set",
                         full_perm, page_req);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        vaddr = 32'hFFFF_FFFF; xlat_mode = 2'b11; seg_map = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (paddr !== 32'h0 || full_perm !== 1'b0 || page_req !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: got paddr=%h perm=%b req=%b, expected all zero",
                     paddr, full_perm, page_req);
        end
        rst_n = 1'b1;

        // R1: translation off, other inputs set
        drive(32'h9ABC_DEF0, 1'b0, 2'b00, 16'hFFFF, $urandom, $urandom);
        drive(32'h1234_5678, 1'b1, 2'b00, 16'hFFFF, $urandom, $urandom);

        // Sweep every segment, both privileges, map all set then all clear
        for (int pass = 0; pass < 2; pass++) begin
            for (int s = 0; s < 16; s++) begin
                for (int u = 0; u < 2; u++) begin
                    logic [31:0] va;
                    va = {s[3:0], 28'($urandom)};
                    drive(va, u[0], 2'b11, (pass == 0) ? 16'hFFFF : 16'h0000,
                          $urandom, $urandom);
                end
            end
        end

        // Each enable bit alone turns translation on (R2)
        drive(32'h7000_0ABC, 1'b0, 2'b01, 16'h0080, 32'h5000_0000, 32'h0);
        drive(32'h8FFF_FFFF, 1'b0, 2'b10, 16'h0100, 32'h0, 32'h0000_000C);
        drive(32'h8FFF_FFFF, 1'b0, 2'b10, 16'hFEFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // Random mixes
        for (int k = 0; k < 40; k++)
            drive($urandom, 1'($urandom), 2'($urandom), 16'($urandom), $urandom, $urandom);

        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule